// File: doc/BRIEF.md
# Set-Associative Cache Tag Unit

This block keeps the tag and valid metadata of one data cache built from 16-bit memory cells. For each access it decides whether the addressed block is already resident. The caller presents an address, an access kind (read or write) and a one-cycle strobe. One cycle later the block returns a done pulse, a hit flag and the index of the set that the access used. No data payload and no backing memory are modelled here. The unit only tracks which blocks would be resident and where they would be placed.

The organisation is fixed at compile time by three parameters: the ways per set, the cells per block and the total capacity in cells. A single way gives a direct-mapped cache. When the capacity equals ways times block size and there is more than one way, the cache is one fully associative set. Writes follow a write-through, write-allocate policy. A write never reports a hit, but it always places or refreshes its block. Each set keeps a least-recently-used order with one age counter per way.

Top module: `ctag_unit`

## Requirements
- R1: After reset every way of every set is invalid, `res_done` and `res_hit` are low, and the first read of any address reports a miss.
- R2: `res_set` equals (address / BLK_CELLS) mod (SIZE_CELLS / (WAYS * BLK_CELLS)). With a single set it is always 0.
- R3: A read whose block is resident reports `res_hit` = 1. Every cell address inside that block hits.
- R4: A read that misses installs its block, so an immediately following read of the same block hits.
- R5: A write always reports `res_hit` = 0, even when its block is resident, and it leaves the block resident so a later read hits.
- R6: A write to a resident block refreshes that block to most recently used without placing a second copy.
- R7: When all ways of a set are valid and a new block must be placed, the least-recently-used way is replaced.
- R8: A read hit makes the hit block most recently used, so it survives the next replacement in that set.
- R9: `res_done` is high exactly in the cycle after `acc_valid` is sampled high and low otherwise. `res_hit` is high only together with `res_done`.
- R10: Accesses to one set never replace or disturb blocks held in another set.
- R11: The full upper address field takes part in the tag compare, so two addresses that share a set index but differ only in the top address bit do not hit each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | Access kind: 0 = read, 1 = write |
| acc_addr | input | ADDR_W | Cell address of the access |
| res_done | output | 1 | Result valid, one cycle after the strobe |
| res_hit | output | 1 | 1 = read hit; 0 = miss or any write |
| res_set | output | SET_W | Set index used by the access |

## Verification
The bench builds two copies that receive the same stimulus. One is a 2-way cache with 2-cell blocks and 16 cells, which gives four sets. The other has 4 ways, 4-cell blocks and 16 cells, which makes it a single fully associative set. The four-set copy lets short sequences fill one set, force an LRU eviction and still see untouched neighbouring sets. The fully associative copy exercises all four age values and the constant zero set index. A timestamp-based reference model in the bench predicts every hit, miss and set index for both shapes.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    // Width of an index over n items; never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/ctag_addr_split.sv
module ctag_addr_split #(
    parameter int ADDR_W    = 16,
    parameter int BLK_CELLS = 2,
    parameter int SETS      = 4,
    parameter int SET_W     = 2,
    parameter int TAG_W     = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int OFF_W = $clog2(BLK_CELLS);
    localparam int IDX_W = $clog2(SETS);

    generate
        if (IDX_W == 0) begin : g_single_set
            assign set_idx = '0;
        end else begin : g_multi_set
            assign set_idx = addr[OFF_W +: IDX_W];
        end
    endgenerate

    assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/ctag_way_match.sv
module ctag_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 13,
    parameter int AGE_W = 1
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        found,
    output logic [AGE_W-1:0]            found_way,
    output logic [AGE_W-1:0]            victim_way
);
    logic [WAYS-1:0] match;
    logic [WAYS-1:0] oldest;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match[w]  = way_vld[w] && (way_tag[w] == look_tag);
            assign oldest[w] = (way_age[w] == AGE_W'(WAYS - 1));
        end
    endgenerate

    always_comb begin
        found      = 1'b0;
        found_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                found     = 1'b1;
                found_way = AGE_W'(w);
            end
        end
    end

    // Empty way first (lowest index), otherwise the oldest one.
    always_comb begin
        logic have_free;
        have_free  = 1'b0;
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (oldest[w]) victim_way = AGE_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) begin
                have_free  = 1'b1;
                victim_way = AGE_W'(w);
            end
        end
    end
endmodule

// File: rtl/ctag_age_update.sv
module ctag_age_update #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 1
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [AGE_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] touch_age;

    always_comb begin
        touch_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (touch_way == AGE_W'(w)) touch_age = age_in[w];
        end
        for (int w = 0; w < WAYS; w++) begin
            if (touch_way == AGE_W'(w)) begin
                age_out[w] = '0;
            end else if (age_in[w] < touch_age) begin
                age_out[w] = age_in[w] + AGE_W'(1);
            end else begin
                age_out[w] = age_in[w];
            end
        end
    end
endmodule

// File: rtl/ctag_unit.sv
module ctag_unit
    import ctag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WAYS       = 2,
    parameter int BLK_CELLS  = 2,
    parameter int SIZE_CELLS = 16,
    localparam int SETS  = SIZE_CELLS / (WAYS * BLK_CELLS),
    localparam int SET_W = idx_width(SETS),
    localparam int AGE_W = idx_width(WAYS),
    localparam int TAG_W = ADDR_W - $clog2(BLK_CELLS) - $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_done,
    output logic              res_hit,
    output logic [SET_W-1:0]  res_set
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age;
        logic                                  done;
        logic                                  hit;
        logic [SET_W-1:0]                      set;
    } state_t;

    state_t st_d, st_q, st_rst;

    logic [SET_W-1:0]           set_idx;
    logic [TAG_W-1:0]           look_tag;
    logic                       found;
    logic [AGE_W-1:0]           found_way, victim_way, touch_way;
    logic [WAYS-1:0]            sel_vld;
    logic [WAYS-1:0][TAG_W-1:0] sel_tag;
    logic [WAYS-1:0][AGE_W-1:0] sel_age, new_age;
    acc_kind_e                  kind;

    ctag_addr_split #(
        .ADDR_W(ADDR_W), .BLK_CELLS(BLK_CELLS), .SETS(SETS),
        .SET_W(SET_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(acc_addr), .set_idx(set_idx), .tag(look_tag)
    );

    assign sel_vld = st_q.vld[set_idx];
    assign sel_tag = st_q.tag[set_idx];
    assign sel_age = st_q.age[set_idx];

    ctag_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_match (
        .way_vld(sel_vld), .way_tag(sel_tag), .way_age(sel_age),
        .look_tag(look_tag), .found(found), .found_way(found_way),
        .victim_way(victim_way)
    );

    assign touch_way = found ? found_way : victim_way;

    ctag_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
        .age_in(sel_age), .touch_way(touch_way), .age_out(new_age)
    );

    // Reset image: all ways empty, ages form a permutation 0..WAYS-1.
    always_comb begin
        st_rst = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                st_rst.age[s][w] = AGE_W'(w);
            end
        end
    end

    always_comb begin
        kind      = acc_kind_e'(acc_write);
        st_d      = st_q;
        st_d.done = acc_valid;
        st_d.hit  = 1'b0;
        if (acc_valid) begin
            st_d.set = set_idx;
            st_d.hit = found && (kind == ACC_READ);
            st_d.vld[set_idx][touch_way] = 1'b1;
            st_d.tag[set_idx][touch_way] = look_tag;
            st_d.age[set_idx]            = new_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign res_done = st_q.done;
    assign res_hit  = st_q.hit;
    assign res_set  = st_q.set;
endmodule

// File: rtl/ctag_unit_chk.sv
module ctag_unit_chk #(
    parameter int ADDR_W     = 16,
    parameter int WAYS       = 2,
    parameter int BLK_CELLS  = 2,
    parameter int SIZE_CELLS = 16,
    localparam int SETS  = SIZE_CELLS / (WAYS * BLK_CELLS),
    localparam int SET_W = ctag_pkg::idx_width(SETS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              res_done,
    input logic              res_hit,
    input logic [SET_W-1:0]  res_set
);
    logic [SET_W-1:0]  exp_set;
    logic              prev_vld_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic              same_blk;

    assign exp_set  = SET_W'((int'(acc_addr) / BLK_CELLS) % SETS);
    assign same_blk = prev_vld_q &&
                      ((int'(acc_addr) / BLK_CELLS) == (int'(prev_addr_q) / BLK_CELLS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld_q  <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_vld_q  <= acc_valid;
            prev_addr_q <= acc_addr;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_done && !res_hit));

    // R9
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_done);

    // R9
    hit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_done);

    // R5
    write_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !res_hit);

    // R2
    set_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (res_set == $past(exp_set)));

    // R4
    repeat_read_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && same_blk) |=> res_hit);
endmodule

bind ctag_unit ctag_unit_chk #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .BLK_CELLS(BLK_CELLS), .SIZE_CELLS(SIZE_CELLS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .res_done(res_done), .res_hit(res_hit), .res_set(res_set)
);

// File: tb/ctag_unit_test.sv
`timescale 1ns/1ps
module ctag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        done_a, hit_a, done_b, hit_b;
    logic [1:0]  set_a;
    logic [0:0]  set_b;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Shape A: 2 ways, 2-cell blocks, 16 cells -> 4 sets.
    ctag_unit #(.ADDR_W(16), .WAYS(2), .BLK_CELLS(2), .SIZE_CELLS(16)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .res_done(done_a), .res_hit(hit_a), .res_set(set_a)
    );

    // Shape B: 4 ways, 4-cell blocks, 16 cells -> one fully associative set.
    ctag_unit #(.ADDR_W(16), .WAYS(4), .BLK_CELLS(4), .SIZE_CELLS(16)) uut_fa (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .res_done(done_b), .res_hit(hit_b), .res_set(set_b)
    );

    // Reference model: last-use timestamps, smallest timestamp is evicted.
    bit m_vld  [2][4][4];
    int m_tag  [2][4][4];
    int m_time [2][4][4];
    int now = 1;

    function automatic bit model_acc(input int c, input bit wr, input int addr,
                                     output int set);
        int blkc  = (c == 0) ? 2 : 4;
        int nsets = (c == 0) ? 4 : 1;
        int nways = (c == 0) ? 2 : 4;
        int bn    = addr / blkc;
        int tg;
        int way   = -1;
        set = bn % nsets;
        tg  = bn / nsets;
        for (int w = 0; w < nways; w++)
            if (way < 0 && m_vld[c][set][w] && m_tag[c][set][w] == tg) way = w;
        model_acc = (way >= 0) && !wr;
        if (way < 0) begin
            for (int w = 0; w < nways; w++)
                if (way < 0 && !m_vld[c][set][w]) way = w;
            if (way < 0) begin
                way = 0;
                for (int w = 1; w < nways; w++)
                    if (m_time[c][set][w] < m_time[c][set][way]) way = w;
            end
        end
        m_vld[c][set][way]  = 1'b1;
        m_tag[c][set][way]  = tg;
        m_time[c][set][way] = now;
        now++;
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive one access at a falling edge; the result is registered at the
    // next rising edge and sampled at the falling edge after it.
    task automatic do_acc(input bit wr, input int addr, input string req,
                          output bit ha, output bit hb);
        int sa, sb;
        ha = model_acc(0, wr, addr, sa);
        hb = model_acc(1, wr, addr, sb);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = addr[15:0];
        @(negedge clk);
        chk(int'(done_a), 1, {req, " done A"});
        chk(int'(done_b), 1, {req, " done B"});
        chk(int'(hit_a), int'(ha), $sformatf("%s hit A addr %0h", req, addr));
        chk(int'(hit_b), int'(hb), $sformatf("%s hit B addr %0h", req, addr));
        chk(int'(set_a), sa, $sformatf("%s set A addr %0h", req, addr));
        chk(int'(set_b), 0, $sformatf("%s set B addr %0h", req, addr));
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk(int'(done_a), 0, {req, " idle done A"});
        chk(int'(done_b), 0, {req, " idle done B"});
        chk(int'(hit_a),  0, {req, " idle hit A"});
        chk(int'(hit_b),  0, {req, " idle hit B"});
    endtask

    task automatic t_reset();
        bit ha, hb;
        chk(int'(done_a), 0, "R1 reset done A");
        chk(int'(hit_b),  0, "R1 reset hit B");
        do_acc(1'b0, 16'h0040, "R1", ha, hb);
        chk(int'(hit_a), 0, "R1 first read misses A");
        do_acc(1'b0, 16'h7ff1, "R1", ha, hb);
        chk(int'(hit_b), 0, "R1 first read misses B");
    endtask

    task automatic t_set_index();
        bit ha, hb;
        do_acc(1'b0, 16'h0006, "R2", ha, hb);
        chk(int'(set_a), 3, "R2 addr 6 -> set 3");
        do_acc(1'b0, 16'h0009, "R2", ha, hb);
        chk(int'(set_a), 0, "R2 addr 9 -> set 0");
        do_acc(1'b0, 16'h0003, "R2", ha, hb);
        chk(int'(set_a), 1, "R2 addr 3 -> set 1");
    endtask

    task automatic t_read_hit();
        bit ha, hb;
        do_acc(1'b0, 16'h0100, "R3", ha, hb);
        do_acc(1'b0, 16'h0101, "R3", ha, hb);
        chk(int'(hit_a), 1, "R3 neighbour cell hits A");
        do_acc(1'b0, 16'h0103, "R3", ha, hb);
        chk(int'(hit_b), 1, "R3 last cell of block hits B");
    endtask

    task automatic t_install();
        bit ha, hb;
        do_acc(1'b0, 16'h0200, "R4", ha, hb);
        chk(int'(hit_a), 0, "R4 cold read misses");
        do_acc(1'b0, 16'h0200, "R4", ha, hb);
        chk(int'(hit_a), 1, "R4 repeat read hits A");
        chk(int'(hit_b), 1, "R4 repeat read hits B");
        idle_chk("R9");
    endtask

    task automatic t_write();
        bit ha, hb;
        do_acc(1'b1, 16'h0300, "R5", ha, hb);
        do_acc(1'b1, 16'h0300, "R5", ha, hb);
        chk(int'(hit_a), 0, "R5 write to resident block reports miss");
        do_acc(1'b0, 16'h0300, "R5", ha, hb);
        chk(int'(hit_a), 1, "R5 read after write hits");
    endtask

    task automatic t_lru_evict();
        bit ha, hb;
        do_acc(1'b0, 16'h1000, "R7", ha, hb);
        do_acc(1'b0, 16'h2000, "R7", ha, hb);
        do_acc(1'b0, 16'h3000, "R7", ha, hb);
        do_acc(1'b0, 16'h2000, "R7", ha, hb);
        chk(int'(hit_a), 1, "R7 younger block kept");
        do_acc(1'b0, 16'h1000, "R7", ha, hb);
        chk(int'(hit_a), 0, "R7 oldest block evicted");
    endtask

    task automatic t_lru_hit();
        bit ha, hb;
        do_acc(1'b0, 16'h0410, "R8", ha, hb);
        do_acc(1'b0, 16'h0420, "R8", ha, hb);
        do_acc(1'b0, 16'h0410, "R8", ha, hb);
        do_acc(1'b0, 16'h0430, "R8", ha, hb);
        do_acc(1'b0, 16'h0410, "R8", ha, hb);
        chk(int'(hit_a), 1, "R8 hit block survives");
        do_acc(1'b0, 16'h0420, "R8", ha, hb);
        chk(int'(hit_a), 0, "R8 untouched block evicted");
        idle_chk("R9");
    endtask

    task automatic t_lru_write();
        bit ha, hb;
        do_acc(1'b0, 16'h0510, "R6", ha, hb);
        do_acc(1'b0, 16'h0520, "R6", ha, hb);
        do_acc(1'b1, 16'h0510, "R6", ha, hb);
        do_acc(1'b0, 16'h0530, "R6", ha, hb);
        do_acc(1'b0, 16'h0520, "R6", ha, hb);
        chk(int'(hit_a), 0, "R6 refreshed write kept, other evicted");
        do_acc(1'b0, 16'h0530, "R6", ha, hb);
        chk(int'(hit_a), 1, "R6 no duplicate copy displaced block");
    endtask

    task automatic t_sets_indep();
        bit ha, hb;
        do_acc(1'b0, 16'h0006, "R10", ha, hb);
        do_acc(1'b0, 16'h4002, "R10", ha, hb);
        do_acc(1'b0, 16'h5002, "R10", ha, hb);
        do_acc(1'b0, 16'h6004, "R10", ha, hb);
        do_acc(1'b0, 16'h7004, "R10", ha, hb);
        do_acc(1'b0, 16'h8004, "R10", ha, hb);
        do_acc(1'b0, 16'h0006, "R10", ha, hb);
        chk(int'(hit_a), 1, "R10 set 3 untouched by sets 1 and 2");
    endtask

    task automatic t_tag();
        bit ha, hb;
        do_acc(1'b0, 16'h0008, "R11", ha, hb);
        do_acc(1'b0, 16'h8008, "R11", ha, hb);
        chk(int'(hit_a), 0, "R11 top bit differs -> miss A");
        chk(int'(hit_b), 0, "R11 top bit differs -> miss B");
        do_acc(1'b0, 16'h8009, "R11", ha, hb);
        chk(int'(hit_a), 1, "R11 same full tag hits");
        idle_chk("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_index();
        t_read_hit();
        t_install();
        t_write();
        t_lru_evict();
        t_lru_hit();
        t_lru_write();
        t_sets_indep();
        t_tag();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule